// File: doc/BRIEF.md
# Load-Linked/Store-Conditional Reservation Monitor

This block sits beside a memory port and decides which stores reach the array when execution contexts run atomic read-modify-write sequences built from a load-linked and a store-conditional. A context is named by a CPU number together with a thread number. Every cycle the block looks at one request. A load-linked records a reservation for the requester. A store-conditional asks whether that reservation still holds. A plain store always writes, and it also breaks any reservation it touches.

Reservations cover a 16-byte granule: the low four address bits are dropped before an address is stored or compared. The table has a fixed, parameterised number of slots. Each context owns at most one slot. When the table is full, a new context takes the slot of the oldest reservation. The write-enable and the conditional result follow the request combinationally in the same cycle. Table changes take effect at the next rising clock edge.

Top module: `resv_monitor`

## Requirements
- R1: A synchronous active-high reset empties the table. A store-conditional issued just after reset fails even if its context made a load-linked before the reset.
- R2: Addresses are compared at 16-byte granularity. A store-conditional to any byte of the granule that the load-linked touched can succeed. One to a different granule fails.
- R3: A store-conditional succeeds only when a valid entry matches its granule, its CPU number and its thread number. On success it drives `wr_en` and `sc_result` high. On failure both are low.
- R4: With an empty table, a store-conditional fails with `wr_en` and `sc_result` low. A plain store always drives `wr_en` high and `sc_result` low.
- R5: A successful store-conditional removes every reservation on its granule, including those held by other contexts.
- R6: A plain store removes every reservation on its granule. Reservations on other granules stay in place.
- R7: A failed store-conditional also removes every reservation on its granule.
- R8: Each context holds at most one reservation. A new load-linked from that context replaces its earlier entry, even when the table is full, and evicts no other context.
- R9: When all slots are taken and a context with no entry issues a load-linked, the entry that was written longest ago is evicted. A later store-conditional from the evicted context fails.
- R10: `req_kind` is encoded as 0 = other access, 1 = load-linked, 2 = plain store, 3 = store-conditional. An "other" access, or any request with `req_valid` low, drives `wr_en` and `sc_result` low and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | Request class (see R10) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_cpu | input | CPU_W | CPU number of the requester |
| req_thread | input | THR_W | Thread number within the CPU |
| wr_en | output | 1 | The store may write the memory |
| sc_result | output | 1 | Store-conditional outcome, 1 on success |

## Verification
The hardest situation to reach from the ports is a full table in which the victim must be chosen by age. It becomes harder after an entry has been replaced in place, because the age order then differs from slot order. The directed tests reset the block and fill every slot from distinct contexts. They then either add a fifth context or reissue a load-linked from an existing context. Store-conditionals from each context then show which entry was lost. The vector walk covers granule aliasing and the clearing rules, because each outcome there shows up directly on `wr_en` and `sc_result`.

// File: rtl/resv_mon_pkg.sv
package resv_mon_pkg;

    typedef enum logic [1:0] {
        KIND_OTHER = 2'd0,
        KIND_LL    = 2'd1,
        KIND_STORE = 2'd2,
        KIND_SC    = 2'd3
    } req_kind_e;

    // Low address bits dropped to form a 16-byte granule tag
    localparam int GRANULE_BITS = 4;

    function automatic logic kind_is_store(req_kind_e k);
        return (k == KIND_STORE) || (k == KIND_SC);
    endfunction

endpackage

// File: rtl/resv_match.sv
module resv_match #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 28,
    parameter int CTX_W   = 6
) (
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
    input  logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx,
    input  logic [TAG_W-1:0]              req_tag,
    input  logic [CTX_W-1:0]              req_ctx,
    output logic [ENTRIES-1:0]            tag_hit,
    output logic [ENTRIES-1:0]            own_hit,
    output logic [ENTRIES-1:0]            resv_hit
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic same_tag;
        logic same_ctx;
        assign same_tag    = (ent_tag[i] == req_tag);
        assign same_ctx    = (ent_ctx[i] == req_ctx);
        assign tag_hit[i]  = ent_valid[i] && same_tag;
        assign own_hit[i]  = ent_valid[i] && same_ctx;
        assign resv_hit[i] = ent_valid[i] && same_tag && same_ctx;
    end

endmodule

// File: rtl/resv_victim.sv
module resv_victim #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0]            own_hit,
    input  logic [ENTRIES-1:0][IDX_W-1:0] ent_age,
    output logic [IDX_W-1:0]              slot
);

    logic [IDX_W-1:0] own_idx, free_idx, old_idx, old_age;
    logic             own_found, free_found;

    always_comb begin
        own_idx    = '0;
        own_found  = 1'b0;
        free_idx   = '0;
        free_found = 1'b0;
        old_idx    = '0;
        old_age    = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (own_hit[i] && !own_found) begin
                own_idx   = IDX_W'(i);
                own_found = 1'b1;
            end
            if (!ent_valid[i] && !free_found) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
            if (ent_valid[i] && ent_age[i] >= old_age) begin
                old_idx = IDX_W'(i);
                old_age = ent_age[i];
            end
        end
        if (own_found)       slot = own_idx;
        else if (free_found) slot = free_idx;
        else                 slot = old_idx;
    end

endmodule

// File: rtl/resv_table.sv
module resv_table #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 28,
    parameter int CTX_W   = 6,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ins_en,
    input  logic [IDX_W-1:0]              ins_slot,
    input  logic [TAG_W-1:0]              ins_tag,
    input  logic [CTX_W-1:0]              ins_ctx,
    input  logic [ENTRIES-1:0]            kill,
    output logic [ENTRIES-1:0]            ent_valid,
    output logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
    output logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx,
    output logic [ENTRIES-1:0][IDX_W-1:0] ent_age
);

    logic [ENTRIES-1:0]            survive;
    logic [ENTRIES-1:0][IDX_W-1:0] age_nxt;

    // Ages stay a dense ranking 0..n-1 of the live entries (0 = newest)
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            survive[i] = ent_valid[i] && !kill[i] &&
                         !(ins_en && (ins_slot == IDX_W'(i)));
        end
        for (int i = 0; i < ENTRIES; i++) begin
            int younger;
            younger = ins_en ? 1 : 0;
            for (int j = 0; j < ENTRIES; j++) begin
                if (survive[j] && (ent_age[j] < ent_age[i])) younger++;
            end
            age_nxt[i] = survive[i] ? IDX_W'(younger) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            ent_tag   <= '0;
            ent_ctx   <= '0;
            ent_age   <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ins_en && (ins_slot == IDX_W'(i))) begin
                    ent_valid[i] <= 1'b1;
                    ent_tag[i]   <= ins_tag;
                    ent_ctx[i]   <= ins_ctx;
                    ent_age[i]   <= '0;
                end else begin
                    ent_valid[i] <= survive[i];
                    ent_age[i]   <= age_nxt[i];
                end
            end
        end
    end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_mon_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CPU_W   = 4,
    parameter int THR_W   = 2,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [THR_W-1:0]  req_thread,
    output logic              wr_en,
    output logic              sc_result
);

    localparam int TAG_W = ADDR_W - GRANULE_BITS;
    localparam int CTX_W = CPU_W + THR_W;
    localparam int IDX_W = $clog2(ENTRIES);

    req_kind_e                     kind;
    logic [TAG_W-1:0]              req_tag;
    logic [CTX_W-1:0]              req_ctx;
    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
    logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx;
    logic [ENTRIES-1:0][IDX_W-1:0] ent_age;
    logic [ENTRIES-1:0]            tag_hit, own_hit, resv_hit;
    logic [ENTRIES-1:0]            kill;
    logic [IDX_W-1:0]              slot;
    logic                          ins_en, is_store, sc_ok;
    logic [ENTRIES-1:0]            resv_valid;

    assign kind     = req_kind_e'(req_kind);
    assign req_tag  = req_addr[ADDR_W-1:GRANULE_BITS];
    assign req_ctx  = {req_cpu, req_thread};
    assign is_store = req_valid && kind_is_store(kind);
    assign ins_en   = req_valid && (kind == KIND_LL);
    assign sc_ok    = req_valid && (kind == KIND_SC) && (|resv_hit);

    assign wr_en      = (req_valid && (kind == KIND_STORE)) || sc_ok;
    assign sc_result  = sc_ok;
    assign kill       = is_store ? tag_hit : '0;
    assign resv_valid = ent_valid;

    resv_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_match (
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .ent_ctx   (ent_ctx),
        .req_tag   (req_tag),
        .req_ctx   (req_ctx),
        .tag_hit   (tag_hit),
        .own_hit   (own_hit),
        .resv_hit  (resv_hit)
    );

    resv_victim #(.ENTRIES(ENTRIES)) u_victim (
        .ent_valid (ent_valid),
        .own_hit   (own_hit),
        .ent_age   (ent_age),
        .slot      (slot)
    );

    resv_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .ins_en    (ins_en),
        .ins_slot  (slot),
        .ins_tag   (req_tag),
        .ins_ctx   (req_ctx),
        .kill      (kill),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .ent_ctx   (ent_ctx),
        .ent_age   (ent_age)
    );

endmodule

// File: rtl/resv_mon_checker.sv
module resv_mon_checker #(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [1:0]         req_kind,
    input logic               wr_en,
    input logic               sc_result,
    input logic [ENTRIES-1:0] resv_valid
);

    a_r1_reset_empties: assert property (@(posedge clk)
        rst |=> (resv_valid == '0));

    a_r4_empty_sc_fails: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd3 && resv_valid == '0) |-> (!wr_en && !sc_result));

    a_r4_plain_store_writes: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2) |-> (wr_en && !sc_result));

    a_r3_result_only_on_sc: assert property (@(posedge clk) disable iff (rst)
        sc_result |-> (wr_en && req_valid && req_kind == 2'd3));

    a_r5_store_never_adds: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind[1]) |=> ($countones(resv_valid) <= $countones($past(resv_valid))));

    a_r8_ll_adds_at_most_one: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1) |=> ($countones(resv_valid) <= $countones($past(resv_valid)) + 1));

    a_r10_idle_no_change: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_kind == 2'd0) |=> $stable(resv_valid));

    a_r10_idle_outputs_low: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_kind == 2'd0) |-> (!wr_en && !sc_result));

endmodule

bind resv_monitor resv_mon_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .wr_en      (wr_en),
    .sc_result  (sc_result),
    .resv_valid (resv_valid)
);

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;

    localparam int NV = 28;
    // {valid, kind[1:0], addr[31:0], cpu[3:0], thread[1:0], exp_wr, exp_res}
    localparam logic [42:0] VEC [NV] = '{
        {1'b1, 2'd3, 32'h0000_0100, 4'd0, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd2, 32'h0000_0100, 4'd0, 2'd0, 1'b1, 1'b0},
        {1'b1, 2'd1, 32'h0000_1004, 4'd1, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_100C, 4'd1, 2'd1, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_1008, 4'd1, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd1, 32'h0000_2004, 4'd1, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_2010, 4'd1, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_200C, 4'd1, 2'd0, 1'b1, 1'b1},
        {1'b1, 2'd1, 32'h0000_3000, 4'd2, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd1, 32'h0000_3008, 4'd3, 2'd1, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_300F, 4'd2, 2'd0, 1'b1, 1'b1},
        {1'b1, 2'd3, 32'h0000_3000, 4'd3, 2'd1, 1'b0, 1'b0},
        {1'b1, 2'd1, 32'h0000_4000, 4'd2, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd2, 32'h0000_5000, 4'd5, 2'd0, 1'b1, 1'b0},
        {1'b1, 2'd3, 32'h0000_4000, 4'd2, 2'd0, 1'b1, 1'b1},
        {1'b1, 2'd1, 32'h0000_4000, 4'd2, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd2, 32'h0000_400C, 4'd5, 2'd0, 1'b1, 1'b0},
        {1'b1, 2'd3, 32'h0000_4000, 4'd2, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd1, 32'h0000_6000, 4'd4, 2'd2, 1'b0, 1'b0},
        {1'b1, 2'd1, 32'h0000_7000, 4'd4, 2'd2, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_6000, 4'd4, 2'd2, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_7000, 4'd4, 2'd2, 1'b1, 1'b1},
        {1'b1, 2'd1, 32'h0000_8000, 4'd6, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd0, 32'h0000_8000, 4'd6, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_8000, 4'd6, 2'd0, 1'b1, 1'b1},
        {1'b1, 2'd1, 32'h0000_9000, 4'd6, 2'd1, 1'b0, 1'b0},
        {1'b0, 2'd2, 32'h0000_9000, 4'd5, 2'd0, 1'b0, 1'b0},
        {1'b1, 2'd3, 32'h0000_9000, 4'd6, 2'd1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cpu = '0;
    logic [1:0]  req_thread = '0;
    logic        wr_en, sc_result;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    resv_monitor u_resv_monitor (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .req_cpu    (req_cpu),
        .req_thread (req_thread),
        .wr_en      (wr_en),
        .sc_result  (sc_result)
    );

    function automatic string req_of(int i);
        if (i < 2)       return "R4";
        else if (i < 5)  return "R3/R7";
        else if (i < 8)  return "R2";
        else if (i < 12) return "R5";
        else if (i < 18) return "R6";
        else if (i < 22) return "R8";
        else             return "R10";
    endfunction

    task automatic check(string req, logic exp_wr, logic exp_res);
        checks++;
        if (wr_en !== exp_wr || sc_result !== exp_res) begin
            errors++;
            $display("FAIL %s: wr_en=%0b sc_result=%0b expected wr_en=%0b sc_result=%0b",
                     req, wr_en, sc_result, exp_wr, exp_res);
        end
    endtask

    // Drive after a falling edge, sample 2 ns later, update lands on the next rising edge
    task automatic issue(logic v, logic [1:0] k, logic [31:0] a, logic [3:0] c, logic [1:0] t);
        @(negedge clk);
        req_valid  = v;
        req_kind   = k;
        req_addr   = a;
        req_cpu    = c;
        req_thread = t;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: idle outputs after reset
        issue(1'b0, 2'd0, 32'h0, 4'd0, 2'd0);
        check("R1", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][42], VEC[i][41:40], VEC[i][39:8], VEC[i][7:4], VEC[i][3:2]);
            check(req_of(i), VEC[i][1], VEC[i][0]);
        end

        // R1: reservation made before reset is gone afterwards
        issue(1'b1, 2'd1, 32'h0000_C000, 4'd7, 2'd0);
        do_reset();
        issue(1'b1, 2'd3, 32'h0000_C000, 4'd7, 2'd0);
        check("R1", 1'b0, 1'b0);

        // R9: five contexts into four slots evicts the first
        do_reset();
        for (int k = 0; k < 5; k++)
            issue(1'b1, 2'd1, 32'h0000_A000 + 32'(k) * 32'h100, 4'(k), 2'd0);
        issue(1'b1, 2'd3, 32'h0000_A000, 4'd0, 2'd0);
        check("R9", 1'b0, 1'b0);
        for (int k = 1; k < 5; k++) begin
            issue(1'b1, 2'd3, 32'h0000_A000 + 32'(k) * 32'h100, 4'(k), 2'd0);
            check("R9", 1'b1, 1'b1);
        end

        // R8: full table, own context reissues, nobody else is evicted
        do_reset();
        for (int k = 1; k < 5; k++)
            issue(1'b1, 2'd1, 32'h0000_A000 + 32'(k) * 32'h100, 4'(k), 2'd0);
        issue(1'b1, 2'd1, 32'h0000_B000, 4'd1, 2'd0);
        for (int k = 2; k < 5; k++) begin
            issue(1'b1, 2'd3, 32'h0000_A000 + 32'(k) * 32'h100, 4'(k), 2'd0);
            check("R8", 1'b1, 1'b1);
        end
        issue(1'b1, 2'd3, 32'h0000_A100, 4'd1, 2'd0);
        check("R8", 1'b0, 1'b0);
        issue(1'b1, 2'd1, 32'h0000_B000, 4'd1, 2'd0);
        issue(1'b1, 2'd3, 32'h0000_B008, 4'd1, 2'd0);
        check("R8", 1'b1, 1'b1);

        // R9: after an in-place replacement, age order (not slot order) picks the victim
        do_reset();
        for (int k = 1; k < 5; k++)
            issue(1'b1, 2'd1, 32'h0000_A000 + 32'(k) * 32'h100, 4'(k), 2'd0);
        issue(1'b1, 2'd1, 32'h0000_B000, 4'd1, 2'd0);
        issue(1'b1, 2'd1, 32'h0000_D000, 4'd9, 2'd0);
        issue(1'b1, 2'd3, 32'h0000_A200, 4'd2, 2'd0);
        check("R9", 1'b0, 1'b0);
        issue(1'b1, 2'd3, 32'h0000_B000, 4'd1, 2'd0);
        check("R9", 1'b1, 1'b1);

        issue(1'b0, 2'd0, 32'h0, 4'd0, 2'd0);
        finish_run();
    end

endmodule